// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Port

This block is the host-facing port of a clock/calendar peripheral. The host reaches it over an 8-bit bus that carries both address and data on the same lines. A strap input selects between two strobe schemes. In the first scheme, one enable strobe is qualified by a direction level. In the second scheme, separate read and write strobes are used and they latch on different edges. Every strobe is brought into a fast system clock through a synchroniser and turned into edge events. A small access state machine then follows the bus cycle.

The port owns the four control/status registers and a bank of general-purpose storage bytes. It passes accesses to the ten time bytes out to the clock core through single-cycle strobes. It collects event pulses from the core into flags and raises an active-low interrupt level. Writes are refused while power is failing and for a programmable hold time after power returns or after system reset. A clear button held long enough fills the storage bank with FFh.

The access machine has four states: `ST_IDLE` (no cycle), `ST_ADDR` (address held, waiting for a data strobe), `ST_READ` (data driven) and `ST_WRITE` (waiting for the latching edge). Its transitions are as follows. An address-strobe fall moves it from IDLE or ADDR into ADDR and relatches the address. ADDR goes to READ or WRITE when the mode's data strobe arrives with select low and the high bank off. READ and WRITE return to IDLE on the mode's closing edge. ADDR, READ and WRITE all drop to IDLE while the hard reset input is low.

Top module: `muxbus_slave`

## Requirements
- R1: The address (bus lines and `bank_hi`) is captured on the falling edge of `addr_strobe`, whatever the level of `sel_n` at that moment.
- R2: With `mode_moto`=1, the cycle starts on a rise of `data_strobe`. `dir_strobe` high selects a read, which drives the data until `data_strobe` falls. `dir_strobe` low selects a write, which stores the bus value present at the fall of `data_strobe`.
- R3: With `mode_moto`=0, a fall of `data_strobe` starts a read that is driven until it rises. A fall of `dir_strobe` starts a write, which stores the bus value present at the rise of `dir_strobe`.
- R4: If `sel_n` is high during the data phase, nothing is driven and nothing is written.
- R5: If the captured `bank_hi` is high, nothing is driven and nothing is written.
- R6: Addresses 00h–09h are time bytes. They produce `time_wr`/`time_rd` with `time_addr` and take their read data from `time_rdata`. Addresses 0Ah–0Dh are control registers A–D. Addresses 0Eh–FFh are the 242 storage bytes.
- R7: Register A bits 6:0 are read/write, with bits 6:4 as the oscillator code. Bit 7 reads `upd_busy` and cannot be written. Register D reads `backup_ok` in bit 7 and zeros elsewhere, and ignores writes.
- R8: Register C reads {INTF, PF, AF, UF, 0, K32, 0, 0} from bit 7 down. K32 (bit 2) is writable only while the oscillator code is 011. It is cleared whenever the code is anything else.
- R9: `evt_set` bits 2/1/0 set PF/AF/UF. INTF is high, and `irq_n` is low, while any flag is set together with its enable in register B: PIE bit 6, AIE bit 5, UIE bit 4. Reading register C clears all flags.
- R10: Register B is fully read/write, except that setting UTI (bit 7) forces UIE (bit 4) to 0.
- R11: While `hard_rst_n` is low, no access completes, `irq_n` is high, and PIE, AIE, UIE, SQWE (bit 3) and all flags are cleared. The other bits of B are kept.
- R12: Writes of every kind are refused while `pwr_fail` is high and for `HOLD_CYCLES` after it falls or after system reset. Reads still work during that time.
- R13: Holding `wipe_n` low for `CLR_CYCLES` with no power fail sets all storage bytes to FFh and leaves the control registers unchanged. A shorter press changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| mode_moto | input | 1 | Strap: 1 = enable-plus-direction strobes, 0 = separate read/write strobes |
| ad_in | input | 8 | Multiplexed address/data, inbound |
| ad_out | output | 8 | Read data, outbound |
| ad_oe | output | 1 | Output enable for `ad_out` |
| addr_strobe | input | 1 | Address strobe; its fall latches the address |
| data_strobe | input | 1 | Data enable (mode 1) or read strobe (mode 0) |
| dir_strobe | input | 1 | Direction level (mode 1) or write strobe (mode 0) |
| sel_n | input | 1 | Active-low chip select for the data phase |
| bank_hi | input | 1 | High-bank select captured with the address; high blocks this port |
| hard_rst_n | input | 1 | Active-low hard reset pin |
| wipe_n | input | 1 | Active-low storage clear button |
| pwr_fail | input | 1 | Power-fail indication |
| upd_busy | input | 1 | Update-in-progress status from the clock core |
| backup_ok | input | 1 | Backup source valid status |
| evt_set | input | 3 | Event pulses: periodic, alarm, update-ended |
| time_rdata | input | 8 | Time byte selected by `time_addr`, from the core |
| time_addr | output | 4 | Time byte index |
| time_wdata | output | 8 | Time byte write data |
| time_wr | output | 1 | One-cycle time byte write strobe |
| time_rd | output | 1 | One-cycle time byte read strobe |
| cfg_a | output | 7 | Register A bits 6:0 |
| cfg_b | output | 8 | Register B |
| irq_n | output | 1 | Active-low interrupt request level |

## Verification
The assertions check the following on every cycle. The bus is released within one cycle of hard reset. Deselect or the high bank never leads to drive. Read and write commits never coincide. UTI never coexists with UIE. K32 falls when the oscillator code leaves 011. A register C read empties the flags. Hard reset clears the enables. A power fail always leaves writes blocked. A clear fills the storage. Only the bench's scenarios can show the rest: the latching edges and data values in each strobe mode, the address decode, the hold window closing, and the short press leaving storage untouched.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE
    } bus_state_t;

    localparam int CTRL_REGS = 4;

    // register B bit positions
    localparam int B_UTI  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;

    // flag vector order: [2]=periodic, [1]=alarm, [0]=update-ended
    localparam int NFLAGS = 3;

    localparam logic [2:0] OSC_C_WRITABLE = 3'b011;

    // synchronised pin order
    localparam int SY_AS   = 0;
    localparam int SY_DS   = 1;
    localparam int SY_RW   = 2;
    localparam int SY_SEL  = 3;
    localparam int SY_HRST = 4;
    localparam int SY_PF   = 5;
    localparam int SY_WIPE = 6;
    localparam int SY_N    = 7;

endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
    parameter int N = 7,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] pipe;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= {STAGES{RST_VAL[i]}};
                    prev <= RST_VAL[i];
                end else begin
                    pipe <= {pipe[STAGES-2:0], din[i]};
                    prev <= pipe[STAGES-1];
                end
            end

            assign lvl[i]  = pipe[STAGES-1];
            assign rise[i] = pipe[STAGES-1] & ~prev;
            assign fall[i] = ~pipe[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/muxbus_guard.sv
module muxbus_guard #(
    parameter int HOLD_CYCLES = 640000,
    parameter int CLR_CYCLES  = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf,
    input  logic wipe_lvl_n,
    output logic wr_block,
    output logic clr_ram
);

    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam int CW = $clog2(CLR_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYCLES);
    localparam logic [CW-1:0] CLR_V  = CW'(CLR_CYCLES);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYCLES - 1);

    logic [HW-1:0] hold_cnt;
    logic [CW-1:0] press_cnt;

    // hold window: reloaded while power is bad, runs down after
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= HOLD_V;
        end else if (pf) begin
            hold_cnt <= HOLD_V;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // press timer saturates so one press clears once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            press_cnt <= '0;
        end else if (wipe_lvl_n || pf) begin
            press_cnt <= '0;
        end else if (press_cnt != CLR_V) begin
            press_cnt <= press_cnt + 1'b1;
        end
    end

    assign wr_block = pf || (hold_cnt != '0);
    assign clr_ram  = !wipe_lvl_n && !pf && (press_cnt == CLR_LAST);

    // R12
    pf_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf |=> wr_block);

    // R13
    clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ram |=> !clr_ram);

endmodule

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
    import muxbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_moto,
    input  logic       bus_en,
    input  logic       as_fall,
    input  logic       ds_rise,
    input  logic       ds_fall,
    input  logic       rw_rise,
    input  logic       rw_fall,
    input  logic       rw_lvl,
    input  logic       sel_lvl_n,
    input  logic [7:0] ad_in,
    input  logic       bank_in,
    input  logic [7:0] rdata,
    output logic [7:0] addr_q,
    output logic       bank_q,
    output logic [7:0] wdata_q,
    output logic       rd_go,
    output logic       wr_go,
    output logic [7:0] ad_out,
    output logic       ad_oe
);

    bus_state_t state, nxt;

    logic open_ok;
    logic rd_end;
    logic wr_end;
    logic commit;

    assign open_ok = bus_en && !sel_lvl_n && !bank_q;
    assign rd_end  = mode_moto ? ds_fall : ds_rise;
    assign wr_end  = mode_moto ? ds_fall : rw_rise;
    assign commit  = (state == ST_WRITE) && wr_end && bus_en && !sel_lvl_n;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (as_fall) nxt = ST_ADDR;
            end
            ST_ADDR: begin
                if (!bus_en) begin
                    nxt = ST_IDLE;
                end else if (as_fall) begin
                    nxt = ST_ADDR;
                end else if (open_ok) begin
                    if (mode_moto) begin
                        if (ds_rise) nxt = rw_lvl ? ST_READ : ST_WRITE;
                    end else begin
                        if (ds_fall)      nxt = ST_READ;
                        else if (rw_fall) nxt = ST_WRITE;
                    end
                end
            end
            ST_READ: begin
                if (!bus_en || rd_end) nxt = ST_IDLE;
            end
            ST_WRITE: begin
                if (!bus_en || wr_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bank_q  <= 1'b0;
            wdata_q <= '0;
            rd_go   <= 1'b0;
            wr_go   <= 1'b0;
            ad_out  <= '0;
            ad_oe   <= 1'b0;
        end else begin
            if (as_fall && (state == ST_IDLE || state == ST_ADDR)) begin
                addr_q <= ad_in;
                bank_q <= bank_in;
            end
            rd_go <= (state == ST_ADDR) && (nxt == ST_READ);
            wr_go <= commit;
            if (commit) wdata_q <= ad_in;
            if ((state == ST_ADDR) && (nxt == ST_READ)) ad_out <= rdata;
            ad_oe <= (nxt == ST_READ);
        end
    end

    // R11
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !ad_oe);

    // R4
    sel_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && sel_lvl_n) |=> !ad_oe);

    // R5
    bank_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !bank_q);

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go && wr_go));

endmodule

// File: rtl/muxbus_regs.sv
module muxbus_regs
    import muxbus_pkg::*;
#(
    parameter int AW = 8,
    parameter int TIME_BYTES = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic [AW-1:0] addr,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [7:0]    wdata,
    input  logic          wr_block,
    input  logic          clr_ram,
    input  logic          upd_busy,
    input  logic          backup_ok,
    input  logic [NFLAGS-1:0] evt_set,
    input  logic [7:0]    time_rdata,
    output logic [7:0]    rdata,
    output logic [$clog2(TIME_BYTES)-1:0] time_addr,
    output logic [7:0]    time_wdata,
    output logic          time_wr,
    output logic          time_rd,
    output logic [6:0]    cfg_a,
    output logic [7:0]    cfg_b,
    output logic          irq_n
);

    localparam int TW        = $clog2(TIME_BYTES);
    localparam int RAM_BASE  = TIME_BYTES + CTRL_REGS;
    localparam int RAM_BYTES = (1 << AW) - RAM_BASE;
    localparam logic [AW-1:0] TIME_END  = AW'(TIME_BYTES);
    localparam logic [AW-1:0] RAM_START = AW'(RAM_BASE);

    logic [6:0]        reg_a;
    logic [7:0]        reg_b;
    logic [NFLAGS-1:0] flags;
    logic              k32;
    logic              intf;
    logic [7:0]        mem [RAM_BYTES];

    logic          hit_time, hit_ctrl, hit_ram;
    logic [AW-1:0] ctrl_off, ram_off;
    logic [1:0]    ctrl_sel;
    logic          we;

    assign hit_time = addr < TIME_END;
    assign hit_ctrl = !hit_time && (addr < RAM_START);
    assign hit_ram  = !hit_time && !hit_ctrl;
    assign ctrl_off = addr - TIME_END;
    assign ram_off  = addr - RAM_START;
    assign ctrl_sel = ctrl_off[1:0];
    assign we       = wr_go && !wr_block;

    assign intf  = |(flags & {reg_b[B_PIE], reg_b[B_AIE], reg_b[B_UIE]});
    assign irq_n = !(intf && bus_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
            flags <= '0;
            k32   <= 1'b0;
        end else begin
            if (we && hit_ctrl && ctrl_sel == 2'd0) reg_a <= wdata[6:0];
            if (we && hit_ctrl && ctrl_sel == 2'd1) begin
                reg_b <= wdata;
                if (wdata[B_UTI]) reg_b[B_UIE] <= 1'b0;
            end
            if (reg_a[6:4] != OSC_C_WRITABLE)          k32 <= 1'b0;
            else if (we && hit_ctrl && ctrl_sel == 2'd2) k32 <= wdata[2];
            if (rd_go && hit_ctrl && ctrl_sel == 2'd2) flags <= evt_set;
            else                                       flags <= flags | evt_set;
            if (!bus_en) begin
                reg_b[B_PIE:B_SQWE] <= '0;
                flags               <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr_ram) begin
            for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (we && hit_ram) begin
            mem[ram_off] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit_time) begin
            rdata = time_rdata;
        end else if (hit_ctrl) begin
            unique case (ctrl_sel)
                2'd0: rdata = {upd_busy, reg_a};
                2'd1: rdata = reg_b;
                2'd2: rdata = {intf, flags, 1'b0, k32, 2'b00};
                2'd3: rdata = {backup_ok, 7'b0};
                default: rdata = 8'h00;
            endcase
        end else begin
            rdata = mem[ram_off];
        end
    end

    assign time_addr  = addr[TW-1:0];
    assign time_wdata = wdata;
    assign time_wr    = we && hit_time;
    assign time_rd    = rd_go && hit_time;
    assign cfg_a      = reg_a;
    assign cfg_b      = reg_b;

    // R10
    uti_uie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_b[B_UTI] |-> !reg_b[B_UIE]);

    // R8
    k32_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a[6:4] != OSC_C_WRITABLE) |=> !k32);

    // R9
    c_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hit_ctrl && ctrl_sel == 2'd2 && evt_set == '0) |=> (flags == '0));

    // R11
    hard_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> (reg_b[B_PIE:B_SQWE] == '0 && flags == '0));

    // R13
    clr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ram |=> (mem[0] == 8'hFF && mem[RAM_BYTES-1] == 8'hFF));

endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
    import muxbus_pkg::*;
#(
    parameter int HOLD_CYCLES = 640000,
    parameter int CLR_CYCLES  = 4000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_moto,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    input  logic       addr_strobe,
    input  logic       data_strobe,
    input  logic       dir_strobe,
    input  logic       sel_n,
    input  logic       bank_hi,
    input  logic       hard_rst_n,
    input  logic       wipe_n,
    input  logic       pwr_fail,
    input  logic       upd_busy,
    input  logic       backup_ok,
    input  logic [2:0] evt_set,
    input  logic [7:0] time_rdata,
    output logic [3:0] time_addr,
    output logic [7:0] time_wdata,
    output logic       time_wr,
    output logic       time_rd,
    output logic [6:0] cfg_a,
    output logic [7:0] cfg_b,
    output logic       irq_n
);

    localparam logic [SY_N-1:0] SYNC_RST = 7'b1011100;

    logic [SY_N-1:0] pins, lvl, rise, fall;
    logic [7:0] addr_q, wdata_q, rdata;
    logic       bank_q, rd_go, wr_go, wr_block, clr_ram;

    assign pins = {wipe_n, pwr_fail, hard_rst_n, sel_n,
                   dir_strobe, data_strobe, addr_strobe};

    muxbus_sync #(
        .N(SY_N), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    muxbus_guard #(
        .HOLD_CYCLES(HOLD_CYCLES), .CLR_CYCLES(CLR_CYCLES)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .pf(lvl[SY_PF]),
        .wipe_lvl_n(lvl[SY_WIPE]), .wr_block(wr_block), .clr_ram(clr_ram)
    );

    muxbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto),
        .bus_en(lvl[SY_HRST]),
        .as_fall(fall[SY_AS]),
        .ds_rise(rise[SY_DS]), .ds_fall(fall[SY_DS]),
        .rw_rise(rise[SY_RW]), .rw_fall(fall[SY_RW]), .rw_lvl(lvl[SY_RW]),
        .sel_lvl_n(lvl[SY_SEL]),
        .ad_in(ad_in), .bank_in(bank_hi), .rdata(rdata),
        .addr_q(addr_q), .bank_q(bank_q), .wdata_q(wdata_q),
        .rd_go(rd_go), .wr_go(wr_go), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    muxbus_regs #(
        .AW(8), .TIME_BYTES(10)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(lvl[SY_HRST]),
        .addr(addr_q), .rd_go(rd_go), .wr_go(wr_go && !bank_q),
        .wdata(wdata_q), .wr_block(wr_block), .clr_ram(clr_ram),
        .upd_busy(upd_busy), .backup_ok(backup_ok), .evt_set(evt_set),
        .time_rdata(time_rdata), .rdata(rdata),
        .time_addr(time_addr), .time_wdata(time_wdata),
        .time_wr(time_wr), .time_rd(time_rd),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .irq_n(irq_n)
    );

endmodule

// File: tb/muxbus_slave_test.sv
module muxbus_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 200;
    localparam int CLRC = 60;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_moto = 1'b1;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic ad_oe;
    logic addr_strobe = 1'b0, data_strobe = 1'b0, dir_strobe = 1'b1;
    logic sel_n = 1'b1, bank_hi = 1'b0, hard_rst_n = 1'b1;
    logic wipe_n = 1'b1, pwr_fail = 1'b0, upd_busy = 1'b0, backup_ok = 1'b1;
    logic [2:0] evt_set = '0;
    logic [7:0] time_rdata = 8'h5A;
    logic [3:0] time_addr;
    logic [7:0] time_wdata;
    logic time_wr, time_rd;
    logic [6:0] cfg_a;
    logic [7:0] cfg_b;
    logic irq_n;

    int checks = 0, errors = 0;
    int twr_n = 0, trd_n = 0;
    logic [3:0] twr_a;
    logic [7:0] twr_d;
    logic [7:0] rd_v;
    logic seen;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muxbus_slave #(.HOLD_CYCLES(HOLD), .CLR_CYCLES(CLRC)) uut (
        .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_strobe(addr_strobe),
        .data_strobe(data_strobe), .dir_strobe(dir_strobe), .sel_n(sel_n),
        .bank_hi(bank_hi), .hard_rst_n(hard_rst_n), .wipe_n(wipe_n),
        .pwr_fail(pwr_fail), .upd_busy(upd_busy), .backup_ok(backup_ok),
        .evt_set(evt_set), .time_rdata(time_rdata), .time_addr(time_addr),
        .time_wdata(time_wdata), .time_wr(time_wr), .time_rd(time_rd),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .irq_n(irq_n)
    );

    always @(negedge clk) begin
        if (time_wr) begin twr_n++; twr_a = time_addr; twr_d = time_wdata; end
        if (time_rd) trd_n++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_idle(input logic m);
        mode_moto = m;
        data_strobe = m ? 1'b0 : 1'b1;
        dir_strobe = 1'b1;
        sel_n = 1'b1;
        wait_cyc(W);
    endtask

    // select stays high during the address phase (R1)
    task automatic addr_phase(input logic [7:0] a, input logic ext);
        ad_in = a; bank_hi = ext; addr_strobe = 1'b1;
        wait_cyc(W);
        addr_strobe = 1'b0;
        wait_cyc(W);
    endtask

    task automatic bus_wr(input logic m, input logic [7:0] a, input logic [7:0] d,
                          input logic csn = 1'b0, input logic ext = 1'b0);
        set_idle(m);
        addr_phase(a, ext);
        sel_n = csn;
        if (m) begin
            dir_strobe = 1'b0; wait_cyc(W);
            data_strobe = 1'b1; wait_cyc(W);
            ad_in = d; wait_cyc(W);
            data_strobe = 1'b0; wait_cyc(W);
            dir_strobe = 1'b1;
        end else begin
            dir_strobe = 1'b0; wait_cyc(W);
            ad_in = d; wait_cyc(W);
            dir_strobe = 1'b1; wait_cyc(W);
        end
        sel_n = 1'b1; bank_hi = 1'b0;
        wait_cyc(W);
    endtask

    task automatic bus_rd(input logic m, input logic [7:0] a, output logic [7:0] d,
                          output logic oe_seen, input logic csn = 1'b0, input logic ext = 1'b0);
        set_idle(m);
        addr_phase(a, ext);
        sel_n = csn;
        if (m) begin dir_strobe = 1'b1; data_strobe = 1'b1; end
        else   begin data_strobe = 1'b0; end
        wait_cyc(W + 2);
        oe_seen = ad_oe; d = ad_out;
        data_strobe = m ? 1'b0 : 1'b1;
        wait_cyc(W + 1);
        sel_n = 1'b1; bank_hi = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic m, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic s;
        bus_rd(m, a, d, s);
        check(req, {7'b0, s}, 8'h01);
        check(req, d, exp);
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        evt_set = e; wait_cyc(1); evt_set = '0; wait_cyc(2);
    endtask

    // {mode, write, addr, data-or-expected}
    localparam logic [17:0] VEC [12] = '{
        {1'b1, 1'b1, 8'h20, 8'h11},   // R2 write storage
        {1'b0, 1'b1, 8'h21, 8'h22},   // R3 write storage
        {1'b1, 1'b0, 8'h21, 8'h22},   // R2 read
        {1'b0, 1'b0, 8'h20, 8'h11},   // R3 read
        {1'b1, 1'b1, 8'hFF, 8'h7E},   // R6 last storage byte
        {1'b0, 1'b0, 8'hFF, 8'h7E},
        {1'b0, 1'b1, 8'h0E, 8'hA5},   // R6 first storage byte
        {1'b1, 1'b0, 8'h0E, 8'hA5},
        {1'b1, 1'b1, 8'h0B, 8'h0E},   // R10 register B
        {1'b0, 1'b0, 8'h0B, 8'h0E},
        {1'b0, 1'b1, 8'h0A, 8'h26},   // R7 register A
        {1'b1, 1'b0, 8'h0A, 8'h26}
    };

    initial begin
        repeat (30000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        check("reset R11", {7'b0, ad_oe}, 8'h00);
        check("reset R9", {7'b0, irq_n}, 8'h01);
        check("reset R10", cfg_b, 8'h00);
        rst_n = 1'b1;
        wait_cyc(HOLD + 60);

        for (int i = 0; i < 12; i++) begin
            if (VEC[i][16]) bus_wr(VEC[i][17], VEC[i][15:8], VEC[i][7:0]);
            else rd_chk(VEC[i][17] ? "R2 vector" : "R3 vector", VEC[i][17], VEC[i][15:8], VEC[i][7:0]);
        end

        // R7 busy bit and read-only register D
        upd_busy = 1'b1;
        rd_chk("R7 busy", 1'b1, 8'h0A, 8'hA6);
        upd_busy = 1'b0;
        bus_wr(1'b0, 8'h0A, 8'hA6);
        rd_chk("R7 bit7 ro", 1'b0, 8'h0A, 8'h26);
        bus_wr(1'b1, 8'h0D, 8'h55);
        rd_chk("R7 regD", 1'b1, 8'h0D, 8'h80);

        // R8 32k enable gated by oscillator code
        bus_wr(1'b1, 8'h0C, 8'h04);
        rd_chk("R8 locked", 1'b1, 8'h0C, 8'h00);
        bus_wr(1'b1, 8'h0A, 8'h36);
        bus_wr(1'b0, 8'h0C, 8'h04);
        rd_chk("R8 open", 1'b0, 8'h0C, 8'h04);
        bus_wr(1'b1, 8'h0A, 8'h26);
        rd_chk("R8 dropped", 1'b1, 8'h0C, 8'h00);

        // R10
        bus_wr(1'b0, 8'h0B, 8'h90);
        rd_chk("R10 uti", 1'b0, 8'h0B, 8'h80);

        // R9 flags and interrupt
        bus_wr(1'b1, 8'h0B, 8'h40);
        pulse_evt(3'b100);
        check("R9 irq low", {7'b0, irq_n}, 8'h00);
        rd_chk("R9 C read", 1'b1, 8'h0C, 8'hC0);
        check("R9 irq high", {7'b0, irq_n}, 8'h01);
        rd_chk("R9 cleared", 1'b0, 8'h0C, 8'h00);
        pulse_evt(3'b010);
        check("R9 masked", {7'b0, irq_n}, 8'h01);
        rd_chk("R9 alarm flag", 1'b1, 8'h0C, 8'h20);

        // R4 deselected data phase
        bus_wr(1'b1, 8'h30, 8'h12);
        bus_wr(1'b1, 8'h30, 8'h99, 1'b1);
        bus_wr(1'b0, 8'h30, 8'h98, 1'b1);
        rd_chk("R4 no write", 1'b0, 8'h30, 8'h12);
        bus_rd(1'b1, 8'h30, rd_v, seen, 1'b1);
        check("R4 no drive", {7'b0, seen}, 8'h00);

        // R5 high bank
        bus_wr(1'b0, 8'h30, 8'h77, 1'b0, 1'b1);
        rd_chk("R5 no write", 1'b1, 8'h30, 8'h12);
        bus_rd(1'b0, 8'h30, rd_v, seen, 1'b0, 1'b1);
        check("R5 no drive", {7'b0, seen}, 8'h00);

        // R6 time bytes
        bus_wr(1'b1, 8'h03, 8'h45);
        check("R6 time wr count", 8'(twr_n), 8'h01);
        check("R6 time addr", {4'b0, twr_a}, 8'h03);
        check("R6 time data", twr_d, 8'h45);
        rd_chk("R6 time read", 1'b0, 8'h07, 8'h5A);
        check("R6 time rd count", 8'(trd_n), 8'h01);

        // R11 hard reset pin
        bus_wr(1'b1, 8'h0B, 8'h7C);
        pulse_evt(3'b001);
        check("R11 pre irq", {7'b0, irq_n}, 8'h00);
        hard_rst_n = 1'b0;
        wait_cyc(6);
        check("R11 irq released", {7'b0, irq_n}, 8'h01);
        bus_rd(1'b1, 8'h30, rd_v, seen);
        check("R11 no access", {7'b0, seen}, 8'h00);
        hard_rst_n = 1'b1;
        wait_cyc(6);
        rd_chk("R11 B bits", 1'b1, 8'h0B, 8'h04);
        rd_chk("R11 flags", 1'b0, 8'h0C, 8'h00);

        // R12 power fail and hold window
        bus_wr(1'b1, 8'h40, 8'h01);
        pwr_fail = 1'b1; wait_cyc(6);
        bus_wr(1'b1, 8'h40, 8'h02);
        rd_chk("R12 during fail", 1'b1, 8'h40, 8'h01);
        pwr_fail = 1'b0; wait_cyc(4);
        bus_wr(1'b0, 8'h40, 8'h03);
        rd_chk("R12 in hold", 1'b0, 8'h40, 8'h01);
        wait_cyc(HOLD + 60);
        bus_wr(1'b0, 8'h40, 8'h04);
        rd_chk("R12 after hold", 1'b1, 8'h40, 8'h04);

        // R13 clear button
        wipe_n = 1'b0; wait_cyc(CLRC / 3); wipe_n = 1'b1; wait_cyc(4);
        rd_chk("R13 short press", 1'b1, 8'h20, 8'h11);
        wipe_n = 1'b0; wait_cyc(CLRC + 20); wipe_n = 1'b1; wait_cyc(4);
        rd_chk("R13 cleared", 1'b0, 8'h20, 8'hFF);
        rd_chk("R13 cleared last", 1'b1, 8'hFF, 8'hFF);
        rd_chk("R13 control kept", 1'b1, 8'h0B, 8'h04);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule